// File: doc/BRIEF.md
# Shared Reservation Table for Multi-Core Atomic Sequences

This block keeps the reservations behind reserve-load / conditional-store pairs for several cores in one place outside the cores. Each reserved granule (an address with its byte offset already removed) lives in exactly one table entry, stamped with the core that set it. The cores never copy this information between each other, so they need no coherence traffic to agree on who holds a reservation.

Every request names an operation and a scope. The scope decides where the check happens. In core-local scope the block only reflects the core's own local pass bit and leaves the table untouched, so this scope works even with no shared table. In global scope only the table is used. In combined scope the local bit and the table must both agree. Requests that need the table compete through a round-robin arbiter, one table access per cycle. All other requests are accepted at once. Each accepted request gets a one-cycle response pulse with a pass bit.

Top module: `xlt_top`

## Requirements
- R1: A plain operation (op code 00 or 11) is granted in the cycle it is presented, answers with pass = 0 whatever its scope, and never changes the table.
- R2: A granule occupies at most one table entry. A reserve-load to a granule already in the table reuses that entry.
- R3: A global conditional store (op 10, scope 10) by the owning core passes once and consumes the reservation. A second store with no new reserve-load fails.
- R4: A reserve-load (op 01) by another core to a reserved granule moves ownership to that core. The old owner's conditional store then fails, and the new owner's passes.
- R5: A combined-scope (scope 11) conditional store passes only when the local pass bit is 1 and the table check passes. A combined store that fails on the local bit leaves the table reservation in place.
- R6: In core-local scope (scope 01, with 00 treated the same), a conditional store answers with the local pass bit. A reserve-load creates no table entry, and a store consumes none.
- R7: Table requests are granted one per cycle in round-robin order. Several cores requesting together are all served in consecutive cycles.
- R8: When all entries are valid, a reserve-load to a new granule replaces the entry that was least recently set. A repeat reserve-load makes an entry the most recent.
- R9: The response pulse appears exactly one cycle after the grant. No response is produced during or right after reset.
- R10: A reserve-load always answers with pass = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_CORES | Request present, one bit per core, held until granted |
| req_op | input | 2*N_CORES | Operation per core: 00 plain, 01 reserve-load, 10 conditional store, 11 plain |
| req_scope | input | 2*N_CORES | Scope per core: 01 local, 10 global, 11 combined, 00 local |
| req_gran | input | GRAN_W*N_CORES | Granule address per core |
| req_local_ok | input | N_CORES | Local reservation pass bit from each core |
| req_grant | output | N_CORES | Request accepted this cycle |
| rsp_valid | output | N_CORES | Response pulse, one cycle after the grant |
| rsp_pass | output | N_CORES | Result of the answered request |

## Verification
Replacing the least recently set entry is the hardest case to reach. The table has to be full, and the age order has to differ from the fill order. The stimulus starts from a fresh reset, fills every entry from one core, and re-reserves the first granule so it becomes the newest. It then reserves a new granule and checks that the second-filled granule lost its reservation while the others survived. Contention is reached by having all cores present table requests on the same edge. The bench then checks that the grant cycles are distinct and consecutive.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    typedef enum logic [1:0] {
        OP_PLAIN  = 2'b00,
        OP_RESV   = 2'b01,
        OP_COND   = 2'b10,
        OP_PLAIN2 = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SCP_NONE   = 2'b00,
        SCP_LOCAL  = 2'b01,
        SCP_GLOBAL = 2'b10,
        SCP_BOTH   = 2'b11
    } scope_e;

    function automatic logic needs_table(logic [1:0] op, logic [1:0] scope);
        return ((op == OP_RESV) || (op == OP_COND)) && scope[1];
    endfunction
endpackage

// File: rtl/xlt_rr_arb.sv
module xlt_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
    } arb_t;

    arb_t st_d, st_q;

    always_comb begin
        logic found;
        st_d  = st_q;
        gnt   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(st_q.ptr) + k) % N;
            if (!found && req[j]) begin
                found  = 1'b1;
                gnt[j] = 1'b1;
                st_d.ptr = PW'((j + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_GRANT_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);  // R7
endmodule

// File: rtl/xlt_table.sv
module xlt_table #(
    parameter int N_CORES = 4,
    parameter int ENTRIES = 4,
    parameter int GRAN_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_resv,
    input  logic                acc_cond,
    input  logic                acc_local_ok,
    input  logic [((N_CORES > 1) ? $clog2(N_CORES) : 1)-1:0] acc_core,
    input  logic [GRAN_W-1:0]   acc_gran,
    output logic                lock_ok
);
    localparam int CW = (N_CORES > 1) ? $clog2(N_CORES) : 1;
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][GRAN_W-1:0] gran;
        logic [ENTRIES-1:0][CW-1:0]     own;
        logic [ENTRIES-1:0][IW-1:0]     age;
    } tbl_t;

    tbl_t st_d, st_q;
    logic [ENTRIES-1:0] hit;
    logic               hit_any, free_any;
    logic [IW-1:0]      hit_idx, free_idx, old_idx, sel_idx;

    always_comb begin
        hit      = '0;
        hit_any  = 1'b0;
        free_any = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        old_idx  = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            hit[e] = st_q.vld[e] && (st_q.gran[e] == acc_gran);
            if (hit[e] && !hit_any) begin
                hit_any = 1'b1;
                hit_idx = IW'(e);
            end
            if (!st_q.vld[e] && !free_any) begin
                free_any = 1'b1;
                free_idx = IW'(e);
            end
            if (st_q.age[e] == IW'(ENTRIES - 1)) old_idx = IW'(e);
        end
        lock_ok = hit_any && (st_q.own[hit_idx] == acc_core);
        sel_idx = hit_any ? hit_idx : (free_any ? free_idx : old_idx);

        st_d = st_q;
        if (acc_valid && acc_resv) begin
            st_d.vld[sel_idx]  = 1'b1;
            st_d.gran[sel_idx] = acc_gran;
            st_d.own[sel_idx]  = acc_core;
            for (int e = 0; e < ENTRIES; e++) begin
                if (IW'(e) == sel_idx)                  st_d.age[e] = '0;
                else if (st_q.age[e] < st_q.age[sel_idx]) st_d.age[e] = st_q.age[e] + 1'b1;
            end
        end
        if (acc_valid && acc_cond && lock_ok && acc_local_ok)
            st_d.vld[hit_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld  <= '0;
            st_q.gran <= '0;
            st_q.own  <= '0;
            for (int e = 0; e < ENTRIES; e++) st_q.age[e] <= IW'(e);
        end else begin
            st_q <= st_d;
        end
    end

    AST_UNIQUE_GRANULE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));  // R2
    AST_RESV_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_resv) |=> (st_q.vld[$past(sel_idx)] &&
                                     st_q.own[$past(sel_idx)] == $past(acc_core)));  // R4
    AST_TOKEN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_cond && lock_ok && acc_local_ok) |=> !st_q.vld[$past(hit_idx)]);  // R3
    AST_NEWEST_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_resv) |=> (st_q.age[$past(sel_idx)] == '0));  // R8
endmodule

// File: rtl/xlt_top.sv
module xlt_top #(
    parameter int N_CORES = 4,
    parameter int ENTRIES = 4,
    parameter int GRAN_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CORES-1:0]          req_valid,
    input  logic [2*N_CORES-1:0]        req_op,
    input  logic [2*N_CORES-1:0]        req_scope,
    input  logic [GRAN_W*N_CORES-1:0]   req_gran,
    input  logic [N_CORES-1:0]          req_local_ok,
    output logic [N_CORES-1:0]          req_grant,
    output logic [N_CORES-1:0]          rsp_valid,
    output logic [N_CORES-1:0]          rsp_pass
);
    import xlt_pkg::*;
    localparam int CW = (N_CORES > 1) ? $clog2(N_CORES) : 1;

    typedef struct packed {
        logic [N_CORES-1:0] vld;
        logic [N_CORES-1:0] pass;
    } rsp_t;

    rsp_t st_d, st_q;
    logic [N_CORES-1:0] tbl_req, tbl_gnt, local_part;
    logic               acc_valid, acc_resv, acc_cond, acc_local_ok, lock_ok;
    logic [CW-1:0]      acc_core;
    logic [GRAN_W-1:0]  acc_gran;

    always_comb begin
        for (int i = 0; i < N_CORES; i++) begin
            tbl_req[i]    = req_valid[i] && needs_table(req_op[2*i +: 2], req_scope[2*i +: 2]);
            local_part[i] = (req_scope[2*i +: 2] == SCP_GLOBAL) ? 1'b1 : req_local_ok[i];
        end
    end

    xlt_rr_arb #(.N(N_CORES)) i_arb (
        .clk (clk),
        .rst_n (rst_n),
        .req (tbl_req),
        .gnt (tbl_gnt)
    );

    always_comb begin
        acc_valid    = |tbl_gnt;
        acc_core     = '0;
        acc_resv     = 1'b0;
        acc_cond     = 1'b0;
        acc_local_ok = 1'b0;
        acc_gran     = '0;
        for (int i = 0; i < N_CORES; i++) begin
            if (tbl_gnt[i]) begin
                acc_core     = CW'(i);
                acc_resv     = (req_op[2*i +: 2] == OP_RESV);
                acc_cond     = (req_op[2*i +: 2] == OP_COND);
                acc_local_ok = local_part[i];
                acc_gran     = req_gran[GRAN_W*i +: GRAN_W];
            end
        end
    end

    xlt_table #(.N_CORES(N_CORES), .ENTRIES(ENTRIES), .GRAN_W(GRAN_W)) i_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_resv     (acc_resv),
        .acc_cond     (acc_cond),
        .acc_local_ok (acc_local_ok),
        .acc_core     (acc_core),
        .acc_gran     (acc_gran),
        .lock_ok      (lock_ok)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_CORES; i++) begin
            logic [1:0] op;
            op           = req_op[2*i +: 2];
            req_grant[i] = tbl_req[i] ? tbl_gnt[i] : req_valid[i];
            st_d.vld[i]  = req_grant[i];
            if (op == OP_RESV)
                st_d.pass[i] = 1'b1;
            else if (op == OP_COND)
                st_d.pass[i] = local_part[i] && (req_scope[2*i+1] ? lock_ok : 1'b1);
            else
                st_d.pass[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_pass  = st_q.pass & st_q.vld;

    AST_ONE_TABLE_USER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tbl_gnt));  // R7

    for (genvar g = 0; g < N_CORES; g++) begin : g_core_chk
        AST_PLAIN_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[g] && (req_op[2*g] == req_op[2*g+1])) |=> (rsp_valid[g] && !rsp_pass[g]));  // R1
        AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[g] |-> $past(req_valid[g]));  // R9
    end
endmodule

// File: tb/test_xlt_top.sv
module test_xlt_top;
    localparam int N  = 4;
    localparam int GW = 16;
    localparam logic [1:0] PL = 2'b00, RS = 2'b01, CD = 2'b10, P3 = 2'b11;
    localparam logic [1:0] S0 = 2'b00, LOC = 2'b01, GLB = 2'b10, BTH = 2'b11;

    logic clk = 0, rst_n = 0;
    logic [N-1:0]    rv = '0, lok = '0;
    logic [2*N-1:0]  rop = '0, rsc = '0;
    logic [GW*N-1:0] rg = '0;
    logic [N-1:0]    gnt, rspv, rspp;

    xlt_top #(.N_CORES(N), .ENTRIES(4), .GRAN_W(GW)) i_xlt_top (
        .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_op(rop), .req_scope(rsc),
        .req_gran(rg), .req_local_ok(lok), .req_grant(gnt), .rsp_valid(rspv), .rsp_pass(rspp)
    );

    always #5 clk = ~clk;

    typedef struct { int core; logic pass; int cyc; string tag; } exp_t;
    exp_t q[$];
    int n_run = 0, n_fail = 0, cyc = 0;
    int gcyc[N];
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic issue(int c, logic [1:0] op, logic [1:0] sc, int gr, logic lk, logic ex, string tag);
        exp_t it;
        logic g;
        @(negedge clk);
        rv[c] = 1'b1; rop[2*c +: 2] = op; rsc[2*c +: 2] = sc;
        rg[GW*c +: GW] = GW'(gr); lok[c] = lk;
        forever begin
            #4 g = gnt[c];
            @(posedge clk);
            if (g) break;
        end
        gcyc[c] = cyc;
        it.core = c; it.pass = ex; it.cyc = cyc + 1; it.tag = tag;
        q.push_back(it);
        #1 rv[c] = 1'b0;
    endtask

    // Monitor: pops the scoreboard entry of each core that answers
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (rspv[i]) begin
                    int idx;
                    idx = -1;
                    for (int k = 0; k < q.size(); k++)
                        if (idx < 0 && q[k].core == i) idx = k;
                    if (idx < 0) begin
                        check(0, "R9", "unexpected response core", i, -1);
                    end else begin
                        check(rspp[i] == q[idx].pass, q[idx].tag, "pass bit", int'(rspp[i]), int'(q[idx].pass));
                        check(cyc == q[idx].cyc, "R9", "response cycle", cyc, q[idx].cyc);
                        q.delete(idx);
                    end
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        check(rspv == '0, "R9", "response during reset", int'(rspv), 0);
        rst_n = 1;
        @(negedge clk);
        check(rspv == '0, "R9", "response after reset", int'(rspv), 0);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R9", "missing responses", q.size(), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        do_reset();
        // R3, R10: token taken once
        issue(0, RS, GLB, 'h10, 0, 1, "R10");
        issue(0, CD, GLB, 'h10, 0, 1, "R3");
        issue(0, CD, GLB, 'h10, 0, 0, "R3");
        // R4, R2: ownership moves
        issue(0, RS, GLB, 'h20, 0, 1, "R10");
        issue(1, RS, GLB, 'h20, 0, 1, "R2");
        issue(0, CD, GLB, 'h20, 0, 0, "R4");
        issue(1, CD, GLB, 'h20, 0, 1, "R4");
        // R1: plain ops ignored
        issue(2, RS, GLB, 'h30, 0, 1, "R10");
        issue(3, PL, GLB, 'h30, 1, 0, "R1");
        issue(3, P3, BTH, 'h30, 1, 0, "R1");
        issue(2, CD, GLB, 'h30, 0, 1, "R1");
        // R6: local scope
        issue(1, RS, LOC, 'h40, 1, 1, "R6");
        issue(1, CD, GLB, 'h40, 0, 0, "R6");
        issue(1, CD, LOC, 'h40, 1, 1, "R6");
        issue(1, CD, LOC, 'h40, 0, 0, "R6");
        issue(1, CD, S0,  'h40, 1, 1, "R6");
        issue(2, RS, GLB, 'h50, 0, 1, "R10");
        issue(2, CD, LOC, 'h50, 1, 1, "R6");
        issue(2, CD, GLB, 'h50, 0, 1, "R6");
        // R5: combined scope
        issue(0, RS, BTH, 'h60, 1, 1, "R10");
        issue(0, CD, BTH, 'h60, 0, 0, "R5");
        issue(0, CD, BTH, 'h60, 1, 1, "R5");
        issue(0, CD, BTH, 'h60, 1, 0, "R5");
        issue(1, RS, BTH, 'h70, 1, 1, "R10");
        issue(2, RS, GLB, 'h70, 0, 1, "R4");
        issue(1, CD, BTH, 'h70, 1, 0, "R5");
        drain();
        // R7: all cores contend on one edge
        fork
            issue(0, RS, GLB, 'h100, 0, 1, "R7");
            issue(1, RS, GLB, 'h101, 0, 1, "R7");
            issue(2, RS, GLB, 'h102, 0, 1, "R7");
            issue(3, RS, GLB, 'h103, 0, 1, "R7");
        join
        begin
            int mn, mx;
            bit dup;
            mn = gcyc[0]; mx = gcyc[0]; dup = 0;
            for (int i = 0; i < N; i++) begin
                if (gcyc[i] < mn) mn = gcyc[i];
                if (gcyc[i] > mx) mx = gcyc[i];
                for (int j = i + 1; j < N; j++) if (gcyc[i] == gcyc[j]) dup = 1;
            end
            check(!dup, "R7", "two grants in one cycle", int'(dup), 0);
            check(mx - mn == N - 1, "R7", "grant spread", mx - mn, N - 1);
        end
        for (int i = 0; i < N; i++) issue(i, CD, GLB, 'h100 + i, 0, 1, "R7");
        drain();
        // R8: replacement of the least recently set entry
        do_reset();
        issue(0, RS, GLB, 'h201, 0, 1, "R10");
        issue(0, RS, GLB, 'h202, 0, 1, "R10");
        issue(0, RS, GLB, 'h203, 0, 1, "R10");
        issue(0, RS, GLB, 'h204, 0, 1, "R10");
        issue(0, RS, GLB, 'h201, 0, 1, "R8");
        issue(0, RS, GLB, 'h205, 0, 1, "R8");
        issue(0, CD, GLB, 'h202, 0, 0, "R8");
        issue(0, CD, GLB, 'h201, 0, 1, "R8");
        issue(0, CD, GLB, 'h203, 0, 1, "R8");
        issue(0, CD, GLB, 'h204, 0, 1, "R8");
        issue(0, CD, GLB, 'h205, 0, 1, "R8");
        drain();
        finish_run();
    end
endmodule